// File: doc/BRIEF.md
# Apparent-Energy Feedback Code Generator

A reconfigurable capacitor-stack energy buffer holds its bus voltage inside a narrow window. It steps through a ladder of switch configurations as it absorbs or releases energy. Because of that, the raw bus voltage no longer tells an outer power-factor-correction loop how much energy is stored. This block builds a substitute signal: an 8-bit code for a DAC that follows the voltage a plain capacitor would show when holding the same energy.

In normal operation the code combines two parts. The first is a staircase that rises evenly from the window floor to the window ceiling as the configuration index climbs through its 24 steps. The second is a small share (1/24) of the bus deviation above the floor, which fills in each step. During precharge the ladder is not yet meaningful, so the code is simply the bus reading reduced to 8 bits. The floor and ceiling are run-time codes on the same 10-bit scale as the bus reading. The code is registered and updates one cycle after either a new bus sample or a change of the configuration index, with a one-cycle write strobe for the DAC.

Top module: `energy_code_gen`

## Requirements
- R1: While reset is asserted and after its release with no trigger, `dacCode` is 0 and `dacWrite` is 0.
- R2: With `prechargeMode`=1, a sample produces `dacCode` equal to bits [9:2] of `busSample` (the reading divided by 4).
- R3: With `prechargeMode`=0, `dacCode` is bits [9:2] of L. Here L = vMin + trunc(((vMax-vMin)*s + (bus-vMin)) / 24), where s is the configuration index. The division truncates toward zero and matches exact integer division for every input combination, including when vMax < vMin.
- R4: When L is negative, `dacCode` is 0.
- R5: When L exceeds 1023, `dacCode` is 255.
- R6: A configuration index above 24 is treated as 24.
- R7: A cycle with `sampleValid`=1 loads the result at the next clock edge, and `dacWrite` is 1 during the cycle after that edge.
- R8: A change of `stateIdx` without a sample reloads the code using the most recently sampled bus value, with the same timing and strobe as R7.
- R9: With no sample and no index change, `dacCode` holds and `dacWrite` stays 0, even when `vMinCode`, `vMaxCode` or `prechargeMode` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prechargeMode | input | 1 | 1 = precharge (scaled copy), 0 = normal (staircase formula) |
| sampleValid | input | 1 | One-cycle flag marking a new bus sample |
| busSample | input | 10 | Digitized bus voltage |
| stateIdx | input | 5 | Configuration ladder index (0..24 meaningful) |
| vMinCode | input | 10 | Window floor code, same scale as the bus reading |
| vMaxCode | input | 10 | Window ceiling code, same scale as the bus reading |
| dacCode | output | 8 | Registered feedback code for the DAC |
| dacWrite | output | 1 | One-cycle DAC write strobe |

## Verification
The bench sweeps the bus reading against every 5-bit index under three windows: a nominal one, a wide one that drives the result past full scale, and an inverted one where the numerator goes negative.

Each of these sweeps targets a specific fault:
- A reciprocal with too few fraction bits shows up as scattered off-by-one codes.
- A floor-style divide shows up as off-by-one codes wherever the numerator is negative.
- A missing clamp shows up as wrapped codes near 0 and 255.
- A missing saturation shows up as wrong codes for indices 25 to 31.

The remaining checks cover the trigger paths. A reload from a stale or fresh bus value on an index-only change would give the wrong code. A design that reacted to window or mode changes would emit a spurious strobe.

// File: rtl/energy_code_pkg.sv
package energy_code_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadBus;  // capture a new bus reading
    logic loadOut;  // register a new output code
  } ecgStrobe_t;

endpackage

// File: rtl/ecg_recip_div.sv
// Signed division by a constant, truncating toward zero.
// The magnitude path multiplies by a rounded-up reciprocal; SHIFT must be
// wide enough that the excess never reaches 1/DIV over the numerator range.
module ecg_recip_div #(
  parameter int NW    = 18,
  parameter int DIV   = 24,
  parameter int SHIFT = 20
) (
  input  logic signed [NW-1:0] num,
  output logic signed [NW-1:0] quot
);

  localparam longint RECIP = ((longint'(1) << SHIFT) + DIV - 1) / DIV;
  localparam int     PW    = NW + SHIFT + 1;

  logic          neg;
  logic [NW-1:0] mag;
  logic [NW-1:0] qMag;

  assign neg = num[NW-1];
  assign mag = neg ? $unsigned(-num) : $unsigned(num);

  generate
    if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      localparam int SH = $clog2(DIV);
      assign qMag = mag >> SH;
    end else begin : g_recip
      logic [PW-1:0] prod;
      assign prod = PW'(mag) * PW'(RECIP);
      assign qMag = NW'(prod >> SHIFT);
    end
  endgenerate

  assign quot = neg ? -$signed(qMag) : $signed(qMag);

endmodule

// File: rtl/ecg_control.sv
// Decides when the output is reloaded: on a bus sample or an index change.
module ecg_control
  import energy_code_pkg::*;
#(
  parameter int STATE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [STATE_W-1:0] stateIdx,
  output ecgStrobe_t         strobes,
  output logic               dacWrite
);

  logic [STATE_W-1:0] prevState;
  logic               stateMoved;

  // Tracks the index every cycle, also during reset, so that the first
  // cycle after reset sees no spurious change.
  always_ff @(posedge clk) begin
    prevState <= stateIdx;
  end

  assign stateMoved      = (stateIdx != prevState);
  assign strobes.loadBus = sampleValid;
  assign strobes.loadOut = sampleValid | stateMoved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dacWrite <= 1'b0;
    else        dacWrite <= strobes.loadOut;
  end

endmodule

// File: rtl/ecg_datapath.sv
// Bus hold register, staircase arithmetic, clamp and output register.
module ecg_datapath
  import energy_code_pkg::*;
#(
  parameter int ADC_W      = 10,
  parameter int OUT_W      = 8,
  parameter int STATE_W    = 5,
  parameter int NUM_STATES = 24,
  parameter int SHIFT      = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ecgStrobe_t         strobes,
  input  logic               prechargeMode,
  input  logic [ADC_W-1:0]   busSample,
  input  logic [STATE_W-1:0] stateIdx,
  input  logic [ADC_W-1:0]   vMinCode,
  input  logic [ADC_W-1:0]   vMaxCode,
  output logic [OUT_W-1:0]   dacCode
);

  localparam int NW = ADC_W + STATE_W + 3;
  localparam logic [STATE_W-1:0] S_TOP = STATE_W'(NUM_STATES);
  localparam logic signed [NW-1:0] LEVEL_MAX = {{(NW-ADC_W){1'b0}}, {ADC_W{1'b1}}};

  logic [ADC_W-1:0]     busHeld;
  logic [ADC_W-1:0]     busNow;
  logic [STATE_W-1:0]   sEff;
  logic signed [NW-1:0] vMinW, vMaxW, busW, sW;
  logic signed [NW-1:0] spanW, stepW, devW, numW, quotW, levelW;
  logic [OUT_W-1:0]     normCode, nextCode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busHeld <= '0;
    else if (strobes.loadBus) busHeld <= busSample;
  end

  assign busNow = strobes.loadBus ? busSample : busHeld;
  assign sEff   = (stateIdx > S_TOP) ? S_TOP : stateIdx;

  assign vMinW = $signed({{(NW-ADC_W){1'b0}}, vMinCode});
  assign vMaxW = $signed({{(NW-ADC_W){1'b0}}, vMaxCode});
  assign busW  = $signed({{(NW-ADC_W){1'b0}}, busNow});
  assign sW    = $signed({{(NW-STATE_W){1'b0}}, sEff});

  assign spanW = vMaxW - vMinW;
  assign stepW = spanW * sW;
  assign devW  = busW - vMinW;
  assign numW  = stepW + devW;

  ecg_recip_div #(
    .NW   (NW),
    .DIV  (NUM_STATES),
    .SHIFT(SHIFT)
  ) u_div (
    .num (numW),
    .quot(quotW)
  );

  assign levelW = vMinW + quotW;

  always_comb begin
    if (levelW < 0)              normCode = '0;
    else if (levelW > LEVEL_MAX) normCode = '1;
    else                         normCode = levelW[ADC_W-1 -: OUT_W];
  end

  assign nextCode = prechargeMode ? busNow[ADC_W-1 -: OUT_W] : normCode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dacCode <= '0;
    else if (strobes.loadOut) dacCode <= nextCode;
  end

endmodule

// File: rtl/energy_code_gen.sv
// Thin top: control plus datapath.
module energy_code_gen
  import energy_code_pkg::*;
#(
  parameter int ADC_W      = 10,
  parameter int OUT_W      = 8,
  parameter int STATE_W    = 5,
  parameter int NUM_STATES = 24,
  parameter int SHIFT      = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prechargeMode,
  input  logic               sampleValid,
  input  logic [ADC_W-1:0]   busSample,
  input  logic [STATE_W-1:0] stateIdx,
  input  logic [ADC_W-1:0]   vMinCode,
  input  logic [ADC_W-1:0]   vMaxCode,
  output logic [OUT_W-1:0]   dacCode,
  output logic               dacWrite
);

  ecgStrobe_t strobes;

  ecg_control #(
    .STATE_W(STATE_W)
  ) u_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .stateIdx   (stateIdx),
    .strobes    (strobes),
    .dacWrite   (dacWrite)
  );

  ecg_datapath #(
    .ADC_W     (ADC_W),
    .OUT_W     (OUT_W),
    .STATE_W   (STATE_W),
    .NUM_STATES(NUM_STATES),
    .SHIFT     (SHIFT)
  ) u_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .prechargeMode(prechargeMode),
    .busSample    (busSample),
    .stateIdx     (stateIdx),
    .vMinCode     (vMinCode),
    .vMaxCode     (vMaxCode),
    .dacCode      (dacCode)
  );

endmodule

// File: rtl/ecg_check.sv
module ecg_check #(
  parameter int ADC_W   = 10,
  parameter int OUT_W   = 8,
  parameter int STATE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prechargeMode,
  input logic               sampleValid,
  input logic [ADC_W-1:0]   busSample,
  input logic [STATE_W-1:0] stateIdx,
  input logic [OUT_W-1:0]   dacCode,
  input logic               dacWrite
);

  assert_precharge_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prechargeMode && sampleValid) |=> dacCode == $past(busSample[ADC_W-1 -: OUT_W]));

  assert_sample_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> dacWrite);

  assert_index_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && !$stable(stateIdx)) |=> dacWrite);

  assert_no_trigger_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && $stable(stateIdx)) |=> !dacWrite);

  assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dacWrite |-> $stable(dacCode));

endmodule

bind energy_code_gen ecg_check #(
  .ADC_W  (ADC_W),
  .OUT_W  (OUT_W),
  .STATE_W(STATE_W)
) u_check (.*);

// File: tb/test_energy_code_gen.sv
module test_energy_code_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prechargeMode = 1'b0;
  logic       sampleValid = 1'b0;
  logic [9:0] busSample = '0;
  logic [4:0] stateIdx = 5'd1;
  logic [9:0] vMinCode = 10'd368;
  logic [9:0] vMaxCode = 10'd450;
  logic [7:0] dacCode;
  logic       dacWrite;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  energy_code_gen i_energy_code_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .prechargeMode(prechargeMode),
    .sampleValid  (sampleValid),
    .busSample    (busSample),
    .stateIdx     (stateIdx),
    .vMinCode     (vMinCode),
    .vMaxCode     (vMaxCode),
    .dacCode      (dacCode),
    .dacWrite     (dacWrite)
  );

  function automatic int expCode(int bus, int st, bit pre, int vmin, int vmax);
    int s, n, lvl;
    if (pre) return bus / 4;
    s   = (st > 24) ? 24 : st;
    n   = (vmax - vmin) * s + (bus - vmin);
    lvl = vmin + n / 24;
    if (lvl < 0) return 0;
    if (lvl > 1023) return 255;
    return lvl / 4;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive a sample at a falling edge, check at the next falling edge.
  task automatic sampleAndCheck(int bus, int st, bit pre, string tag);
    @(negedge clk);
    busSample     = 10'(bus);
    stateIdx      = 5'(st);
    prechargeMode = pre;
    sampleValid   = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    chk(dacCode, expCode(bus, st, pre, vMinCode, vMaxCode), tag);
  endtask

  task automatic sweepWindow(int vmin, int vmax);
    vMinCode = 10'(vmin);
    vMaxCode = 10'(vmax);
    for (int st = 0; st < 32; st++) begin
      for (int bus = 0; bus < 1024; bus += 11) begin
        string tag;
        if (st > 24) tag = "R6";
        else if (expCode(bus, st, 0, vmin, vmax) == 0) tag = "R4/R3";
        else if (expCode(bus, st, 0, vmin, vmax) == 255) tag = "R5/R3";
        else tag = "R3";
        sampleAndCheck(bus, st, 1'b0, tag);
      end
      sampleAndCheck(1023, st, 1'b0, "R3");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dacCode, 0, "R1 in reset code");
    chk(dacWrite, 0, "R1 in reset strobe");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dacCode, 0, "R1 after reset code");
    chk(dacWrite, 0, "R1 after reset strobe");

    // R2: precharge copies the bus reading scaled by 1/4
    for (int bus = 0; bus < 1024; bus++) sampleAndCheck(bus, 3, 1'b1, "R2");

    // R7: strobe high for exactly the cycle after the load edge
    @(negedge clk);
    busSample     = 10'd400;
    stateIdx      = 5'd12;
    prechargeMode = 1'b0;
    sampleValid   = 1'b1;
    chk(dacWrite, 0, "R7 strobe before edge");
    @(negedge clk);
    sampleValid = 1'b0;
    chk(dacWrite, 1, "R7 strobe after load");
    chk(dacCode, expCode(400, 12, 0, 368, 450), "R7 code after load");
    @(negedge clk);
    chk(dacWrite, 0, "R7 strobe single cycle");

    // R8: an index change alone reloads with the held bus reading
    busSample = 10'd5;  // not sampled; must be ignored
    stateIdx  = 5'd20;
    @(negedge clk);
    chk(dacWrite, 1, "R8 strobe on index change");
    chk(dacCode, expCode(400, 20, 0, 368, 450), "R8 code uses held bus");
    @(negedge clk);
    chk(dacWrite, 0, "R8 strobe single cycle");
    stateIdx = 5'd2;
    @(negedge clk);
    chk(dacCode, expCode(400, 2, 0, 368, 450), "R8 code after step down");

    // R9: window and mode changes alone do nothing
    @(negedge clk);
    vMinCode      = 10'd100;
    vMaxCode      = 10'd900;
    prechargeMode = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(dacWrite, 0, "R9 no strobe");
      chk(dacCode, expCode(400, 2, 0, 368, 450), "R9 code holds");
    end

    // R3..R6: windows covering nominal, overflow and negative numerators
    sweepWindow(368, 450);
    sweepWindow(600, 1023);
    sweepWindow(200, 40);

    // Explicit corners
    vMinCode = 10'd40;
    vMaxCode = 10'd0;
    sampleAndCheck(0, 24, 1'b0, "R4 negative level clamps to 0");
    vMinCode = 10'd600;
    vMaxCode = 10'd1023;
    sampleAndCheck(1023, 24, 1'b0, "R5 level above full scale clamps to 255");
    sampleAndCheck(700, 31, 1'b0, "R6 index 31 acts as 24");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule